// File: doc/BRIEF.md
# Interrupt Router Indirect Register File

This block holds the programmable state of an interrupt routing controller. Software reaches it through two 32-bit words on a memory-mapped bus. The word at byte offset 0 is a register-select latch. The word at byte offset 16 is a data window onto whichever internal register the latch names. The internal registers are:

- a device ID;
- a read-only version/capacity word;
- an arbitration ID;
- a table of 64-bit routing entries. Each routing entry is seen as two 32-bit halves at consecutive indices.

Every table entry's decoded fields are driven out in parallel to the delivery logic. The delivery logic reads them directly and never goes through the bus. Read data is registered. Illegal bus accesses and accesses to undefined register indices each raise a one-cycle flag.

Top module: `irq_route_regs`

## Requirements
- R1: Only accesses with `bus_bytes` equal to 4 and `bus_addr` equal to 0 or 16 are legal. Any other access changes no state and returns read data 0. In the cycle after such an access, `bus_fault` is high for one cycle.
- R2: A legal write at offset 0 stores `bus_wdata[7:0]` in the select latch. A read at offset 0 returns the latch zero-extended to 32 bits. The latch resets to 0.
- R3: Index 0 is the device ID. A write stores `bus_wdata[27:24]`. A read returns the ID in bits 27:24 and zero in all other bits. The reset value is parameter `RESET_ID`.
- R4: Index 1 always reads as `NUM_ENTRIES-1` in bits 23:16 and `VERSION` (default 0x11) in bits 7:0, with zero elsewhere. Writes to index 1 change nothing.
- R5: Index 2 is the arbitration ID. It has the same bit layout as index 0 and resets to `RESET_ID`.
- R6: Indices 0x10 up to 0x10+2*NUM_ENTRIES-1 (inclusive) map to table entry (index-0x10)/2. An even index reaches bits 31:0 of the entry and an odd index reaches bits 63:32. A write changes only that half.
- R7: A write to a low half keeps only the bits in mask 0x0001AFFF. A write to a high half keeps only the bits in mask 0xFF000000. All other bits are stored as zero.
- R8: At reset, every entry's low half is 0x00010000 (mask bit set) and every entry's high half is 0.
- R9: Undefined indices are 3 to 0x0F and from 0x10+2*NUM_ENTRIES upwards. A data-window read of an undefined index returns 0, and a write to one has no effect. Either access raises `reg_undef` for one cycle in the following cycle.
- R10: The exported fields for entry e come from the entry's 64-bit value, as follows:
  - vector: bits 7:0
  - delivery mode: bits 10:8
  - logical destination mode: bit 11
  - polarity: bit 13
  - level trigger: bit 15
  - mask: bit 16
  - destination: bits 63:56

  Each field is packed at position e in its flattened output bus.
- R11: `bus_rdata` takes the result of a read on the clock edge that accepts the read. It then holds that value until the next read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_bytes | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_fault | output | 1 | Illegal offset or size flag, one cycle |
| reg_undef | output | 1 | Undefined register index flag, one cycle |
| dev_id | output | 4 | Current device ID |
| arb_id | output | 4 | Current arbitration ID |
| ent_vector | output | 8*NUM_ENTRIES | Vector field of every entry |
| ent_mode | output | 3*NUM_ENTRIES | Delivery mode of every entry |
| ent_logical | output | NUM_ENTRIES | Logical destination mode flags |
| ent_polarity | output | NUM_ENTRIES | Polarity flags |
| ent_level | output | NUM_ENTRIES | Level-trigger flags |
| ent_mask | output | NUM_ENTRIES | Mask flags |
| ent_dest | output | 8*NUM_ENTRIES | Destination of every entry |

## Verification
A corrupted select latch or a wrong index decode sends data-window accesses to the wrong register. The next read then returns another register's contents, and the exported fields of a different entry change one cycle after a write. A lost reserved-bit clear or a wrong reset value appears at the first read of that half, or at once on the exported mask and vector buses. Random traffic is compared read by read against a bench model, so any such fault shows within a few accesses of the one that caused it.

// File: rtl/irrf_pkg.sv
package irrf_pkg;
   localparam logic [7:0]  IDX_DEVID = 8'h00;
   localparam logic [7:0]  IDX_VER   = 8'h01;
   localparam logic [7:0]  IDX_ARB   = 8'h02;
   localparam int unsigned TBL_BASE  = 16;
   localparam int unsigned OFF_SEL   = 0;
   localparam int unsigned OFF_WIN   = 16;
   localparam logic [2:0]  ACC_BYTES = 3'd4;

   // bits kept on a write; every other bit is reserved and stored as zero
   localparam logic [31:0] KEEP_LO   = 32'h0001_AFFF;
   localparam logic [31:0] KEEP_HI   = 32'hFF00_0000;
   localparam logic [31:0] LO_RESET  = 32'h0001_0000;

   typedef struct packed {
      logic [7:0] dest;
      logic       mask;
      logic       level;
      logic       polarity;
      logic       logical;
      logic [2:0] mode;
      logic [7:0] vector;
   } route_fields_t;

   function automatic route_fields_t unpack_entry(input logic [31:0] lo, input logic [31:0] hi);
      route_fields_t f;
      f.vector   = lo[7:0];
      f.mode     = lo[10:8];
      f.logical  = lo[11];
      f.polarity = lo[13];
      f.level    = lo[15];
      f.mask     = lo[16];
      f.dest     = hi[31:24];
      return f;
   endfunction
endpackage

// File: rtl/irrf_decode.sv
module irrf_decode
   import irrf_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int NUM_ENTRIES = 24
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic                   bus_write,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [2:0]             bus_bytes,
   input  logic [7:0]             sel,
   output logic                   legal,
   output logic                   acc_sel,
   output logic                   hit_id,
   output logic                   hit_ver,
   output logic                   hit_arb,
   output logic                   hit_tbl,
   output logic                   hit_hi,
   output logic [$clog2(NUM_ENTRIES)-1:0] tbl_idx,
   output logic                   wr_sel,
   output logic                   wr_id,
   output logic                   wr_arb,
   output logic [NUM_ENTRIES-1:0] we_lo,
   output logic [NUM_ENTRIES-1:0] we_hi,
   output logic                   fault_q,
   output logic                   undef_q
);
   localparam int IDX_W   = $clog2(NUM_ENTRIES);
   localparam int TBL_END = TBL_BASE + 2 * NUM_ENTRIES;

   logic       acc_win;
   logic       known;
   logic [9:0] sel_w;
   logic [9:0] tbl_off;

   always_comb begin
      legal   = bus_valid && (bus_bytes == ACC_BYTES) &&
                ((bus_addr == ADDR_W'(OFF_SEL)) || (bus_addr == ADDR_W'(OFF_WIN)));
      acc_sel = legal && (bus_addr == ADDR_W'(OFF_SEL));
      acc_win = legal && (bus_addr == ADDR_W'(OFF_WIN));
      sel_w   = {2'b00, sel};
      tbl_off = sel_w - 10'(TBL_BASE);
      hit_id  = (sel == IDX_DEVID);
      hit_ver = (sel == IDX_VER);
      hit_arb = (sel == IDX_ARB);
      hit_tbl = (sel_w >= 10'(TBL_BASE)) && (sel_w < 10'(TBL_END));
      hit_hi  = sel[0];
      tbl_idx = IDX_W'(tbl_off >> 1);
      known   = hit_id || hit_ver || hit_arb || hit_tbl;
      wr_sel  = acc_sel && bus_write;
      wr_id   = acc_win && bus_write && hit_id;
      wr_arb  = acc_win && bus_write && hit_arb;
   end

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_we
      always_comb begin
         we_lo[e] = acc_win && bus_write && hit_tbl && !hit_hi && (tbl_idx == IDX_W'(e));
         we_hi[e] = acc_win && bus_write && hit_tbl &&  hit_hi && (tbl_idx == IDX_W'(e));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         undef_q <= 1'b0;
      end else begin
         fault_q <= bus_valid && !legal;
         undef_q <= acc_win && !known;
      end
   end

   // R1 R9
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_q && undef_q));
   // R6
   one_half_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({we_lo, we_hi}));
   // R1
   fault_only_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !legal) |=> fault_q);
endmodule

// File: rtl/irrf_entry.sv
module irrf_entry
   import irrf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we_lo,
   input  logic        we_hi,
   input  logic [31:0] wdata,
   output logic [31:0] lo_q,
   output logic [31:0] hi_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= LO_RESET;
         hi_q <= '0;
      end else begin
         if (we_lo) lo_q <= wdata & KEEP_LO;
         if (we_hi) hi_q <= wdata & KEEP_HI;
      end
   end

   // R7
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lo_q & ~KEEP_LO) == '0) && ((hi_q & ~KEEP_HI) == '0));
   // R6
   hi_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_hi |=> $stable(hi_q));
   // R6
   lo_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_lo |=> $stable(lo_q));
endmodule

// File: rtl/irrf_rdmux.sv
module irrf_rdmux
   import irrf_pkg::*;
#(
   parameter int          NUM_ENTRIES = 24,
   parameter logic [7:0]  VERSION     = 8'h11
)(
   input  logic                               legal,
   input  logic                               acc_sel,
   input  logic                               hit_id,
   input  logic                               hit_ver,
   input  logic                               hit_arb,
   input  logic                               hit_tbl,
   input  logic                               hit_hi,
   input  logic [$clog2(NUM_ENTRIES)-1:0]     tbl_idx,
   input  logic [7:0]                         sel,
   input  logic [3:0]                         id,
   input  logic [3:0]                         arb,
   input  logic [NUM_ENTRIES-1:0][31:0]       ent_lo,
   input  logic [NUM_ENTRIES-1:0][31:0]       ent_hi,
   output logic [31:0]                        word
);
   localparam int IDX_W = $clog2(NUM_ENTRIES);
   localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

   logic [NUM_ENTRIES-1:0][31:0] term;
   logic [31:0]                  tbl_word;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_term
      always_comb begin
         if (tbl_idx == IDX_W'(e)) term[e] = hit_hi ? ent_hi[e] : ent_lo[e];
         else                      term[e] = '0;
      end
   end

   always_comb begin
      tbl_word = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) tbl_word = tbl_word | term[e];
      if (!legal)        word = '0;
      else if (acc_sel)  word = {24'h0, sel};
      else if (hit_id)   word = {4'h0, id, 24'h0};
      else if (hit_ver)  word = VER_WORD;
      else if (hit_arb)  word = {4'h0, arb, 24'h0};
      else if (hit_tbl)  word = tbl_word;
      else               word = '0;
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irrf_pkg::*;
#(
   parameter int         NUM_ENTRIES = 24,
   parameter int         ADDR_W      = 8,
   parameter logic [7:0] VERSION     = 8'h11,
   parameter logic [3:0] RESET_ID    = 4'h1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_valid,
   input  logic                     bus_write,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [2:0]               bus_bytes,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic                     bus_fault,
   output logic                     reg_undef,
   output logic [3:0]               dev_id,
   output logic [3:0]               arb_id,
   output logic [8*NUM_ENTRIES-1:0] ent_vector,
   output logic [3*NUM_ENTRIES-1:0] ent_mode,
   output logic [NUM_ENTRIES-1:0]   ent_logical,
   output logic [NUM_ENTRIES-1:0]   ent_polarity,
   output logic [NUM_ENTRIES-1:0]   ent_level,
   output logic [NUM_ENTRIES-1:0]   ent_mask,
   output logic [8*NUM_ENTRIES-1:0] ent_dest
);
   localparam int IDX_W = $clog2(NUM_ENTRIES);

   if (NUM_ENTRIES < 2 || NUM_ENTRIES > 120) begin : g_bad_entries
      $error("NUM_ENTRIES must lie in 2..120");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 16");
   end

   logic                         legal, acc_sel;
   logic                         hit_id, hit_ver, hit_arb, hit_tbl, hit_hi;
   logic [IDX_W-1:0]             tbl_idx;
   logic                         wr_sel, wr_id, wr_arb;
   logic [NUM_ENTRIES-1:0]       we_lo, we_hi;
   logic [7:0]                   sel_q;
   logic [3:0]                   id_q, arb_q;
   logic [31:0]                  rd_word;
   logic [NUM_ENTRIES-1:0][31:0] ent_lo, ent_hi;

   irrf_decode #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_decode (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_bytes(bus_bytes), .sel(sel_q),
      .legal(legal), .acc_sel(acc_sel), .hit_id(hit_id), .hit_ver(hit_ver),
      .hit_arb(hit_arb), .hit_tbl(hit_tbl), .hit_hi(hit_hi), .tbl_idx(tbl_idx),
      .wr_sel(wr_sel), .wr_id(wr_id), .wr_arb(wr_arb),
      .we_lo(we_lo), .we_hi(we_hi), .fault_q(bus_fault), .undef_q(reg_undef)
   );

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      route_fields_t f;
      irrf_entry u_entry (
         .clk(clk), .rst_n(rst_n), .we_lo(we_lo[e]), .we_hi(we_hi[e]),
         .wdata(bus_wdata), .lo_q(ent_lo[e]), .hi_q(ent_hi[e])
      );
      always_comb begin
         f                 = unpack_entry(ent_lo[e], ent_hi[e]);
         ent_vector[8*e+:8] = f.vector;
         ent_mode[3*e+:3]   = f.mode;
         ent_logical[e]     = f.logical;
         ent_polarity[e]    = f.polarity;
         ent_level[e]       = f.level;
         ent_mask[e]        = f.mask;
         ent_dest[8*e+:8]   = f.dest;
      end
   end

   irrf_rdmux #(.NUM_ENTRIES(NUM_ENTRIES), .VERSION(VERSION)) u_rdmux (
      .legal(legal), .acc_sel(acc_sel), .hit_id(hit_id), .hit_ver(hit_ver),
      .hit_arb(hit_arb), .hit_tbl(hit_tbl), .hit_hi(hit_hi), .tbl_idx(tbl_idx),
      .sel(sel_q), .id(id_q), .arb(arb_q), .ent_lo(ent_lo), .ent_hi(ent_hi),
      .word(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= '0;
         id_q      <= RESET_ID;
         arb_q     <= RESET_ID;
         bus_rdata <= '0;
      end else begin
         if (wr_sel) sel_q <= bus_wdata[7:0];
         if (wr_id)  id_q  <= bus_wdata[27:24];
         if (wr_arb) arb_q <= bus_wdata[27:24];
         if (bus_valid && !bus_write) bus_rdata <= rd_word;
      end
   end

   assign dev_id = id_q;
   assign arb_id = arb_q;

   // R2
   sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_bytes == 3'd4 && bus_addr == '0)
      |=> sel_q == $past(bus_wdata[7:0]));
   // R5
   arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(arb_id));
   // R3
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(dev_id));
   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> $stable(bus_rdata));
   // R1
   illegal_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_bytes != 3'd4) |=> bus_rdata == '0);
endmodule

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;
   localparam int         NE  = 24;
   localparam logic [3:0] RID = 4'h1;

   logic clk = 0, rst_n = 0;
   logic bus_valid = 0, bus_write = 0;
   logic [7:0]  bus_addr = 0;
   logic [2:0]  bus_bytes = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic bus_fault, reg_undef;
   logic [3:0] dev_id, arb_id;
   logic [8*NE-1:0] ent_vector, ent_dest;
   logic [3*NE-1:0] ent_mode;
   logic [NE-1:0] ent_logical, ent_polarity, ent_level, ent_mask;

   irq_route_regs #(.NUM_ENTRIES(NE), .RESET_ID(RID)) dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_fault(bus_fault), .reg_undef(reg_undef),
      .dev_id(dev_id), .arb_id(arb_id), .ent_vector(ent_vector), .ent_mode(ent_mode),
      .ent_logical(ent_logical), .ent_polarity(ent_polarity), .ent_level(ent_level),
      .ent_mask(ent_mask), .ent_dest(ent_dest)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   logic [7:0]  m_sel;
   logic [3:0]  m_id, m_arb;
   logic [31:0] m_lo [NE];
   logic [31:0] m_hi [NE];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit is_known(input logic [7:0] s);
      return (s <= 8'h02) || (s >= 8'h10 && int'(s) < 16 + 2 * NE);
   endfunction

   function automatic logic [31:0] model_read(input logic [7:0] s);
      if (s == 8'h00) return {4'h0, m_id, 24'h0};
      if (s == 8'h01) return {8'h00, 8'(NE - 1), 8'h00, 8'h11};
      if (s == 8'h02) return {4'h0, m_arb, 24'h0};
      if (s >= 8'h10 && int'(s) < 16 + 2 * NE)
         return s[0] ? m_hi[(int'(s) - 16) / 2] : m_lo[(int'(s) - 16) / 2];
      return 32'h0;
   endfunction

   task automatic model_write(input logic [7:0] s, input logic [31:0] d);
      if (s == 8'h00) m_id = d[27:24];
      else if (s == 8'h02) m_arb = d[27:24];
      else if (s >= 8'h10 && int'(s) < 16 + 2 * NE) begin
         if (s[0]) m_hi[(int'(s) - 16) / 2] = d & 32'hFF00_0000;
         else      m_lo[(int'(s) - 16) / 2] = d & 32'h0001_AFFF;
      end
   endtask

   // one access; outputs sampled at the falling edge after the accepting edge
   task automatic access(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                         input logic [31:0] d, output logic [31:0] rd,
                         output logic flt, output logic und);
      @(negedge clk);
      bus_valid = 1; bus_write = wr; bus_addr = a; bus_bytes = sz; bus_wdata = d;
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
      rd = bus_rdata; flt = bus_fault; und = reg_undef;
   endtask

   task automatic check_fields(input int e);
      chk("R10 vector",   32'(ent_vector[8*e+:8]), 32'(m_lo[e][7:0]));
      chk("R10 mode",     32'(ent_mode[3*e+:3]),   32'(m_lo[e][10:8]));
      chk("R10 logical",  32'(ent_logical[e]),     32'(m_lo[e][11]));
      chk("R10 polarity", 32'(ent_polarity[e]),    32'(m_lo[e][13]));
      chk("R10 level",    32'(ent_level[e]),       32'(m_lo[e][15]));
      chk("R8 R10 mask",  32'(ent_mask[e]),        32'(m_lo[e][16]));
      chk("R10 dest",     32'(ent_dest[8*e+:8]),   32'(m_hi[e][31:24]));
   endtask

   task automatic set_sel(input logic [7:0] s);
      logic [31:0] rd; logic f, u;
      access(1, 8'd0, 3'd4, {24'h0, s}, rd, f, u);
      m_sel = s;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] rd, held; logic f, u;
      void'($urandom(32'd12345));
      m_sel = 0; m_id = RID; m_arb = RID;
      for (int e = 0; e < NE; e++) begin m_lo[e] = 32'h0001_0000; m_hi[e] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // reset state
      access(0, 8'd0, 3'd4, 0, rd, f, u); chk("R2 reset select", rd, 32'h0);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R3 reset id", rd, {4'h0, RID, 24'h0});
      set_sel(8'h02);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R5 reset arb", rd, {4'h0, RID, 24'h0});
      for (int e = 0; e < NE; e++) check_fields(e);
      set_sel(8'h2F);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R8 reset hi", rd, 32'h0);
      set_sel(8'h2E);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R8 reset lo", rd, 32'h0001_0000);

      // version word, write ignored
      set_sel(8'h01);
      access(1, 8'd16, 3'd4, 32'hFFFF_FFFF, rd, f, u);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R4 version", rd, 32'h0017_0011);

      // reserved clearing, both halves
      set_sel(8'h10);
      access(1, 8'd16, 3'd4, 32'hFFFF_FFFF, rd, f, u); model_write(8'h10, 32'hFFFF_FFFF);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R7 lo keep", rd, 32'h0001_AFFF);
      set_sel(8'h11);
      access(1, 8'd16, 3'd4, 32'hFFFF_FFFF, rd, f, u); model_write(8'h11, 32'hFFFF_FFFF);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R7 hi keep", rd, 32'hFF00_0000);
      check_fields(0);

      // table edges
      set_sel(8'h3F);
      access(1, 8'd16, 3'd4, 32'hA500_0000, rd, f, u); model_write(8'h3F, 32'hA500_0000);
      chk("R6 last index defined", 32'(u), 0);
      check_fields(NE - 1);
      set_sel(8'h40);
      access(1, 8'd16, 3'd4, 32'hFFFF_FFFF, rd, f, u); chk("R9 write past end flag", 32'(u), 1);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R9 read past end", rd, 0);
      chk("R9 undef read flag", 32'(u), 1);
      set_sel(8'h05);
      access(0, 8'd16, 3'd4, 0, rd, f, u); chk("R9 gap read", rd, 0);

      // illegal size and offset
      access(0, 8'd16, 3'd2, 0, rd, f, u); chk("R1 bad size fault", 32'(f), 1);
      chk("R1 bad size rdata", rd, 0);
      access(1, 8'd0, 3'd2, 32'h0000_0011, rd, f, u);
      access(0, 8'd0, 3'd4, 0, rd, f, u); chk("R1 bad size no write", rd, 32'h05);
      access(1, 8'd4, 3'd4, 32'h12, rd, f, u); chk("R1 bad offset fault", 32'(f), 1);
      @(negedge clk); chk("R1 fault is one cycle", 32'(bus_fault), 0);

      // read data hold
      set_sel(8'h01);
      access(0, 8'd16, 3'd4, 0, held, f, u);
      repeat (3) @(negedge clk);
      access(1, 8'd0, 3'd4, 32'h10, rd, f, u); m_sel = 8'h10;
      chk("R11 rdata holds", bus_rdata, held);

      // random traffic
      for (int n = 0; n < 1500; n++) begin
         int k;
         logic [31:0] d;
         k = int'($urandom % 10);
         d = $urandom;
         if (k < 3) begin
            logic [7:0] s;
            s = 8'($urandom % 72);
            access(1, 8'd0, 3'd4, {d[31:8], s}, rd, f, u); m_sel = s;
            access(0, 8'd0, 3'd4, 0, rd, f, u); chk("R2 select readback", rd, {24'h0, m_sel});
         end else if (k < 6) begin
            access(1, 8'd16, 3'd4, d, rd, f, u);
            chk("R9 write flag", 32'(u), 32'(!is_known(m_sel)));
            model_write(m_sel, d);
            if (m_sel >= 8'h10 && int'(m_sel) < 16 + 2 * NE) check_fields((int'(m_sel) - 16) / 2);
            chk("R3 dev id out", 32'(dev_id), 32'(m_id));
            chk("R5 arb id out", 32'(arb_id), 32'(m_arb));
         end else if (k < 9) begin
            access(0, 8'd16, 3'd4, 0, rd, f, u);
            chk("R6 window read", rd, model_read(m_sel));
            chk("R9 read flag", 32'(u), 32'(!is_known(m_sel)));
            chk("R1 no fault", 32'(f), 0);
         end else begin
            logic [7:0] a;
            a = 8'($urandom % 32);
            if (a == 8'd0 || a == 8'd16) a = 8'd8;
            access(d[0], a, 3'd4, d, rd, f, u);
            chk("R1 random bad offset", 32'(f), 1);
            access(0, 8'd16, 3'd4, 0, rd, f, u);
            chk("R1 state unchanged", rd, model_read(m_sel));
         end
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule